// File: doc/BRIEF.md
# Stack Frame Micro-op Sequencer

This block expands one 16-bit compressed instruction from a 32-bit RISC-V core's stack-frame group into simple micro-operations. The group covers register-list push, pop, pop-and-return and pop-and-return-with-zero, plus the two register-pair moves between s-registers and a0/a1. The block emits the micro-operations one per cycle on a valid/ready port. Each one is a word store, a word load, a stack-pointer adjustment, a register move, an a0 clear or a jump to ra.

Upstream presents the instruction with `in_valid` and holds it stable until `in_ready` is high. The decoder works on the held word throughout the sequence. A reserved encoding is answered in the same cycle with `in_illegal` and `in_ready`, and no micro-operation is issued for it. A `flush` pulse drops the sequence in progress and returns the block to idle.

The controller has six states:
- IDLE waits for an instruction.
- XFER issues one store or load per accepted cycle.
- SPADJ issues the stack-pointer update.
- ZERO issues the a0 clear.
- RET issues the jump.
- MOVE issues the two pair moves.

The transitions are:
- IDLE to XFER on a legal push or pop form.
- IDLE to MOVE on a legal move form.
- XFER to SPADJ after the last transfer.
- SPADJ to IDLE for push and pop, to RET for plain return, and to ZERO for return-with-zero.
- ZERO to RET.
- RET to IDLE.
- MOVE to IDLE after the second move.
- Any state to IDLE on flush.

Top module: `stack_frame_seq`

## Requirements
- R1: An instruction is recognised only when bits[1:0]=2'b10.
  - Bits[15:10]=6'b101110 with bits[9:8]=2'b00 is push, and with 2'b10 is pop.
  - Bits[15:10]=6'b101111 with bits[9:8]=2'b10 is pop-return, and with 2'b00 is pop-return-with-zero.
  - Bits[15:10]=6'b101011 with bits[6:5]=2'b11 is move-to-a, and with 2'b01 is move-from-a.
  - Every other word is illegal.
- R2: An illegal word is reported in the same cycle it is presented in IDLE, with `in_illegal`=1 and `in_ready`=1. No micro-operation follows. Push and pop forms whose list code bits[7:4] is 0 to 3 are illegal.
- R3: The register list is selected by code c in bits[7:4].
  - Position 0 is x1. Position 1 is x8. Position 2 is x9. Position p≥3 is x(p+15).
  - The list holds c-3 entries for codes 4 to 14, and 13 entries for code 15.
  - Push emits stores (uop_op=0, rs=register, rd=0), highest position first. The k-th store (k from 0) has imm = -4(k+1).
- R4: The three pop forms emit loads (uop_op=1, rd=register, rs=2), in the same order as push. The k-th load has imm = adj-4(k+1).
- R5: The adjustment is adj = base + 16·bits[3:2]. The base is 16 for codes 4 to 7, 32 for codes 8 to 11, 48 for codes 12 to 14 and 64 for code 15. After the transfers comes one update (uop_op=2, rd=rs=2), with imm=-adj for push and +adj otherwise. For push and pop this update carries `uop_last`.
- R6: Pop-return then emits a jump (uop_op=5, rd=0, rs=1, imm=0). Pop-return-with-zero first emits a clear (uop_op=4, rd=10, rs=0, imm=0) and then the jump. The jump carries `uop_last`.
- R7: In the move forms, fields bits[9:7] (a) and bits[4:2] (b) map value 0 to x8, 1 to x9 and v≥2 to x(v+16).
  - Move-to-a emits uop_op=3 with rd=10 rs=a, then rd=11 rs=b.
  - Move-from-a emits rd=a rs=10, then rd=b rs=11.
  - imm is 0 for both moves.
  - Equal fields make the word illegal.
- R8: While `uop_valid` is high and `uop_ready` is low, the offered micro-operation stays unchanged. `in_ready` is high for a legal word only in the cycle its last micro-operation is accepted.
- R9: A `flush` sampled at a clock edge leaves `uop_valid` and `in_ready` low from the next cycle until a new instruction is started.
- R10: After reset, and in the cycle a legal word is first presented, `uop_valid` is low. The first micro-operation is offered one cycle later. After the last micro-operation is accepted, `uop_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Abort the current sequence |
| in_valid | input | 1 | Instruction word present |
| in_instr | input | 16 | Compressed instruction, held until in_ready |
| in_ready | output | 1 | Instruction consumed |
| in_illegal | output | 1 | Word is a reserved encoding, consumed with no micro-ops |
| uop_valid | output | 1 | Micro-operation offered |
| uop_ready | input | 1 | Downstream accepts the micro-operation |
| uop_op | output | 3 | Kind: 0 store, 1 load, 2 sp update, 3 move, 4 clear, 5 jump |
| uop_rd | output | 5 | Destination register |
| uop_rs | output | 5 | Source or data register |
| uop_imm | output | 12 | Signed offset or adjustment |
| uop_last | output | 1 | Final micro-operation of the instruction |

## Verification
Outputs are sampled shortly after the falling edge, with `uop_ready` driven at that edge.

- **Illegal words.** `in_illegal` and `in_ready` are due in the very cycle the word is presented, since they are combinational from the idle state.
- **Legal words.** A legal word gives one silent cycle and then its first micro-operation. Each following micro-operation appears one cycle after the previous one is accepted. The bench therefore compares the expected list in acceptance order, whatever the random ready pattern.
- **End of a sequence.** `in_ready` is checked in the acceptance cycle of the last entry. An idle output is checked in the next cycle.
- **Flush.** Its effect is checked one edge after it is sampled.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int REG_W = 5;
    localparam int IMM_W = 12;
    localparam int CNT_W = 4;
    localparam int INSTR_W = 16;

    localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
    localparam logic [REG_W-1:0] REG_RA   = 5'd1;
    localparam logic [REG_W-1:0] REG_SP   = 5'd2;
    localparam logic [REG_W-1:0] REG_A0   = 5'd10;
    localparam logic [REG_W-1:0] REG_A1   = 5'd11;

    typedef enum logic [2:0] {
        OP_STORE = 3'd0,
        OP_LOAD  = 3'd1,
        OP_SPADJ = 3'd2,
        OP_MOVE  = 3'd3,
        OP_ZERO  = 3'd4,
        OP_RET   = 3'd5
    } uop_op_e;

    typedef enum logic [2:0] {
        F_PUSH,
        F_POP,
        F_POPRET,
        F_POPRETZ,
        F_MV_TO_A,
        F_MV_FROM_A
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_SPADJ,
        ST_ZERO,
        ST_RET,
        ST_MOVE
    } state_e;

    // Register at a list position: ra, s0, s1, then s2 upward.
    function automatic logic [REG_W-1:0] list_reg(input logic [CNT_W-1:0] pos);
        if (pos == 4'd0) return REG_RA;
        if (pos == 4'd1) return 5'd8;
        if (pos == 4'd2) return 5'd9;
        return REG_W'(pos) + 5'd15;
    endfunction

    // Three-bit s-register field to register number.
    function automatic logic [REG_W-1:0] sreg_of(input logic [2:0] f);
        if (f == 3'd0) return 5'd8;
        if (f == 3'd1) return 5'd9;
        return REG_W'(f) + 5'd16;
    endfunction
endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
    import sfs_pkg::*;
#(
    parameter int FRAME_UNIT = 16,
    parameter int ADJ_W      = 8
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               legal,
    output form_e              form,
    output logic [CNT_W-1:0]   count,
    output logic [ADJ_W-1:0]   adj,
    output logic [REG_W-1:0]   sreg_a,
    output logic [REG_W-1:0]   sreg_b
);
    logic [5:0] grp;
    logic [1:0] sub;
    logic [3:0] code;
    logic [1:0] extra;
    logic [2:0] base_units;
    logic       list_ok;

    assign grp   = instr[15:10];
    assign sub   = instr[9:8];
    assign code  = instr[7:4];
    assign extra = instr[3:2];

    assign list_ok = (code >= 4'd4);
    assign sreg_a  = sreg_of(instr[9:7]);
    assign sreg_b  = sreg_of(instr[4:2]);

    always_comb begin
        if (code == 4'd15)       base_units = 3'd4;
        else if (code >= 4'd12)  base_units = 3'd3;
        else if (code >= 4'd8)   base_units = 3'd2;
        else                     base_units = 3'd1;
    end

    assign count = (code == 4'd15) ? CNT_W'(13) : CNT_W'(code - 4'd3);
    assign adj   = ADJ_W'(FRAME_UNIT * (int'(base_units) + int'(extra)));

    always_comb begin
        legal = 1'b0;
        form  = F_PUSH;
        if (instr[1:0] == 2'b10) begin
            case (grp)
                6'b101110: begin
                    if (sub == 2'b00) begin
                        form  = F_PUSH;
                        legal = list_ok;
                    end else if (sub == 2'b10) begin
                        form  = F_POP;
                        legal = list_ok;
                    end
                end
                6'b101111: begin
                    if (sub == 2'b10) begin
                        form  = F_POPRET;
                        legal = list_ok;
                    end else if (sub == 2'b00) begin
                        form  = F_POPRETZ;
                        legal = list_ok;
                    end
                end
                6'b101011: begin
                    if (instr[6:5] == 2'b11) begin
                        form  = F_MV_TO_A;
                        legal = (instr[9:7] != instr[4:2]);
                    end else if (instr[6:5] == 2'b01) begin
                        form  = F_MV_FROM_A;
                        legal = (instr[9:7] != instr[4:2]);
                    end
                end
                default: legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
    import sfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             legal,
    input  form_e            form,
    input  logic [CNT_W-1:0] count,
    input  logic             fire,
    output state_e           state_q,
    output logic [CNT_W-1:0] idx_q
);
    state_e           state_nx;
    logic [CNT_W-1:0] idx_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nx;
            idx_q   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && legal) begin
                    idx_nx = '0;
                    if (form == F_MV_TO_A || form == F_MV_FROM_A) state_nx = ST_MOVE;
                    else                                          state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (fire) begin
                    if (idx_q == count - CNT_W'(1)) begin
                        state_nx = ST_SPADJ;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx_q + CNT_W'(1);
                    end
                end
            end
            ST_SPADJ: begin
                if (fire) begin
                    if (form == F_POPRET)       state_nx = ST_RET;
                    else if (form == F_POPRETZ) state_nx = ST_ZERO;
                    else                        state_nx = ST_IDLE;
                end
            end
            ST_ZERO: if (fire) state_nx = ST_RET;
            ST_RET:  if (fire) state_nx = ST_IDLE;
            ST_MOVE: begin
                if (fire) begin
                    if (idx_q == CNT_W'(1)) begin
                        state_nx = ST_IDLE;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = CNT_W'(1);
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        if (flush) begin
            state_nx = ST_IDLE;
            idx_nx   = '0;
        end
    end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
    import sfs_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int FRAME_UNIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               in_ready,
    output logic               in_illegal,
    output logic               uop_valid,
    input  logic               uop_ready,
    output logic [2:0]         uop_op,
    output logic [REG_W-1:0]   uop_rd,
    output logic [REG_W-1:0]   uop_rs,
    output logic [IMM_W-1:0]   uop_imm,
    output logic               uop_last
);
    localparam int ADJ_W = $clog2(FRAME_UNIT * 7 + 1);

    logic             legal;
    form_e            form;
    logic [CNT_W-1:0] count;
    logic [ADJ_W-1:0] adj;
    logic [REG_W-1:0] sreg_a;
    logic [REG_W-1:0] sreg_b;
    state_e           state_q;
    logic [CNT_W-1:0] idx_q;
    logic             fire;
    logic [IMM_W-1:0] step;
    logic [IMM_W-1:0] adj_ext;
    logic [CNT_W-1:0] pos;

    sfs_decode #(
        .FRAME_UNIT (FRAME_UNIT),
        .ADJ_W      (ADJ_W)
    ) u_decode (
        .instr  (in_instr),
        .legal  (legal),
        .form   (form),
        .count  (count),
        .adj    (adj),
        .sreg_a (sreg_a),
        .sreg_b (sreg_b)
    );

    sfs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .in_valid (in_valid),
        .legal    (legal),
        .form     (form),
        .count    (count),
        .fire     (fire),
        .state_q  (state_q),
        .idx_q    (idx_q)
    );

    assign fire       = uop_valid && uop_ready;
    assign in_illegal = (state_q == ST_IDLE) && in_valid && !legal;
    assign in_ready   = (fire && uop_last) || in_illegal;

    assign step    = IMM_W'(WORD_BYTES * (int'(idx_q) + 1));
    assign adj_ext = IMM_W'(adj);
    assign pos     = count - idx_q - CNT_W'(1);

    always_comb begin
        uop_valid = 1'b0;
        uop_op    = OP_STORE;
        uop_rd    = REG_ZERO;
        uop_rs    = REG_ZERO;
        uop_imm   = '0;
        uop_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: uop_valid = 1'b0;
            ST_XFER: begin
                uop_valid = 1'b1;
                if (form == F_PUSH) begin
                    uop_op  = OP_STORE;
                    uop_rs  = list_reg(pos);
                    uop_imm = '0 - step;
                end else begin
                    uop_op  = OP_LOAD;
                    uop_rd  = list_reg(pos);
                    uop_rs  = REG_SP;
                    uop_imm = adj_ext - step;
                end
            end
            ST_SPADJ: begin
                uop_valid = 1'b1;
                uop_op    = OP_SPADJ;
                uop_rd    = REG_SP;
                uop_rs    = REG_SP;
                uop_imm   = (form == F_PUSH) ? ('0 - adj_ext) : adj_ext;
                uop_last  = (form == F_PUSH) || (form == F_POP);
            end
            ST_ZERO: begin
                uop_valid = 1'b1;
                uop_op    = OP_ZERO;
                uop_rd    = REG_A0;
            end
            ST_RET: begin
                uop_valid = 1'b1;
                uop_op    = OP_RET;
                uop_rs    = REG_RA;
                uop_last  = 1'b1;
            end
            ST_MOVE: begin
                uop_valid = 1'b1;
                uop_op    = OP_MOVE;
                uop_last  = (idx_q == CNT_W'(1));
                if (form == F_MV_TO_A) begin
                    uop_rd = (idx_q == '0) ? REG_A0 : REG_A1;
                    uop_rs = (idx_q == '0) ? sreg_a : sreg_b;
                end else begin
                    uop_rd = (idx_q == '0) ? sreg_a : sreg_b;
                    uop_rs = (idx_q == '0) ? REG_A0 : REG_A1;
                end
            end
            default: uop_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
    import sfs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_illegal,
    input logic             uop_valid,
    input logic             uop_ready,
    input logic [2:0]       uop_op,
    input logic [REG_W-1:0] uop_rd,
    input logic [REG_W-1:0] uop_rs,
    input logic [IMM_W-1:0] uop_imm,
    input logic             uop_last
);
    // R2: an illegal word is consumed at once and starts nothing
    assert_illegal_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_illegal |-> (in_ready && in_valid && !uop_valid));

    assert_illegal_no_uop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_illegal |=> !uop_valid);

    // R3: every store lands below the current stack pointer
    assert_store_below_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_op == OP_STORE) |-> (uop_imm[IMM_W-1] && uop_rd == REG_ZERO));

    // R5: the stack update always targets sp and is never zero
    assert_spadj_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_op == OP_SPADJ) |-> (uop_rd == REG_SP && uop_rs == REG_SP && uop_imm != '0));

    // R6: the jump ends the sequence
    assert_jump_is_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_op == OP_RET) |-> (uop_last && uop_rs == REG_RA));

    // R8: a stalled micro-operation is held unchanged
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready && !flush) |=>
            (uop_valid && $stable(uop_op) && $stable(uop_rd) && $stable(uop_rs)
             && $stable(uop_imm) && $stable(uop_last)));

    // R9: flush empties the output
    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!uop_valid && !in_ready));

    // R10: a bubble follows the final accepted micro-operation
    assert_bubble_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |=> !uop_valid);
endmodule

bind stack_frame_seq sfs_checker u_chk (.*);

// File: tb/stack_frame_seq_tb.sv
module stack_frame_seq_tb;
    import sfs_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        in_ready;
    logic        in_illegal;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [2:0]  uop_op;
    logic [4:0]  uop_rd;
    logic [4:0]  uop_rs;
    logic [11:0] uop_imm;
    logic        uop_last;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int e_n;
    bit e_ill;
    int e_op[16];
    int e_rd[16];
    int e_rs[16];
    int e_imm[16];

    always #10 clk = ~clk;

    stack_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_instr(in_instr),
        .in_ready(in_ready), .in_illegal(in_illegal), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_op(uop_op), .uop_rd(uop_rd), .uop_rs(uop_rs), .uop_imm(uop_imm), .uop_last(uop_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d instr=%h", req, act, exp, in_instr);
        end
    endtask

    function automatic int lreg(input int p);
        if (p == 0) return 1;
        if (p == 1) return 8;
        if (p == 2) return 9;
        return p + 15;
    endfunction

    function automatic int sreg(input int v);
        if (v == 0) return 8;
        if (v == 1) return 9;
        return v + 16;
    endfunction

    function automatic void put(input int op, input int rd, input int rs, input int imm);
        e_op[e_n] = op; e_rd[e_n] = rd; e_rs[e_n] = rs; e_imm[e_n] = imm;
        e_n++;
    endfunction

    // Expected micro-operation list from the requirements (R1..R7)
    function automatic void build(input logic [15:0] w);
        int code, cnt, adj, base, a, b;
        bit pu, po, pr, prz, mta, mfa;
        e_n = 0; e_ill = 1'b1;
        pu = 0; po = 0; pr = 0; prz = 0; mta = 0; mfa = 0;
        code = int'(w[7:4]);
        if (w[1:0] == 2'b10) begin
            if (w[15:10] == 6'b101110 && w[9:8] == 2'b00) pu = 1;
            if (w[15:10] == 6'b101110 && w[9:8] == 2'b10) po = 1;
            if (w[15:10] == 6'b101111 && w[9:8] == 2'b10) pr = 1;
            if (w[15:10] == 6'b101111 && w[9:8] == 2'b00) prz = 1;
            if (w[15:10] == 6'b101011 && w[6:5] == 2'b11) mta = 1;
            if (w[15:10] == 6'b101011 && w[6:5] == 2'b01) mfa = 1;
        end
        if ((pu || po || pr || prz) && code >= 4) begin
            e_ill = 1'b0;
            cnt  = (code == 15) ? 13 : code - 3;
            base = (code <= 7) ? 16 : (code <= 11) ? 32 : (code <= 14) ? 48 : 64;
            adj  = base + 16 * int'(w[3:2]);
            for (int k = 0; k < cnt; k++) begin
                if (pu) put(0, 0, lreg(cnt - 1 - k), -4 * (k + 1));
                else    put(1, lreg(cnt - 1 - k), 2, adj - 4 * (k + 1));
            end
            put(2, 2, 2, pu ? -adj : adj);
            if (prz) put(4, 10, 0, 0);
            if (pr || prz) put(5, 0, 1, 0);
        end else if (mta || mfa) begin
            a = sreg(int'(w[9:7]));
            b = sreg(int'(w[4:2]));
            if (a != b) begin
                e_ill = 1'b0;
                if (mta) begin put(3, 10, a, 0); put(3, 11, b, 0); end
                else     begin put(3, a, 10, 0); put(3, b, 11, 0); end
            end
        end
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R7";
            default: return "R6";
        endcase
    endfunction

    // Present one word at a falling edge and follow it to completion.
    task automatic run_one(input logic [15:0] w, input bit always_ready);
        int k;
        bit fin;
        int guard;
        build(w);
        in_instr = w;
        in_valid = 1'b1;
        uop_ready = 1'b0;
        #1;
        if (e_ill) begin
            check(in_illegal && in_ready && !uop_valid, "R2 illegal same cycle",
                  int'({in_illegal, in_ready, uop_valid}), 3'b110);
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            check(!uop_valid && !in_illegal, "R2 no uop after illegal", int'(uop_valid), 0);
            return;
        end
        check(!uop_valid && !in_ready && !in_illegal, "R10 idle on presentation",
              int'({uop_valid, in_ready, in_illegal}), 0);
        @(negedge clk);
        #1;
        check(uop_valid, "R10 first uop one cycle later", int'(uop_valid), 1);
        k = 0; fin = 1'b0; guard = 0;
        while (!fin && guard < 400) begin
            uop_ready = always_ready ? 1'b1 : (($urandom % 4) != 0);
            #1;
            if (uop_valid && uop_ready) begin
                if (k >= e_n) begin
                    check(1'b0, "R8 extra uop", k, e_n);
                    fin = 1'b1;
                end else begin
                    check(int'(uop_op) == e_op[k] && int'(uop_rd) == e_rd[k] && int'(uop_rs) == e_rs[k]
                          && int'($signed(uop_imm)) == e_imm[k], tag_of(e_op[k]),
                          int'(uop_op) * 1000000 + int'(uop_rd) * 10000 + int'(uop_rs) * 100 + int'($signed(uop_imm)),
                          e_op[k] * 1000000 + e_rd[k] * 10000 + e_rs[k] * 100 + e_imm[k]);
                    check(uop_last == (k == e_n - 1), "R8 last flag", int'(uop_last), int'(k == e_n - 1));
                    check(in_ready == (k == e_n - 1), "R8 in_ready on last", int'(in_ready), int'(k == e_n - 1));
                    if (uop_last) fin = 1'b1;
                    k++;
                end
            end else begin
                check(!in_ready, "R8 in_ready low while pending", int'(in_ready), 0);
            end
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0;
        uop_ready = 1'b0;
        check(fin && k == e_n, "R8 sequence complete", k, e_n);
        #1;
        check(!uop_valid, "R10 bubble after last", int'(uop_valid), 0);
    endtask

    function automatic logic [15:0] rand_word();
        logic [15:0] w;
        case ($urandom % 6)
            0: w = {6'b101110, (($urandom % 2) != 0) ? 2'b00 : 2'b10, 4'($urandom), 2'($urandom), 2'b10};
            1: w = {6'b101111, (($urandom % 2) != 0) ? 2'b00 : 2'b10, 4'($urandom), 2'($urandom), 2'b10};
            2: w = {6'b101011, 3'($urandom), (($urandom % 2) != 0) ? 2'b11 : 2'b01, 3'($urandom), 2'b10};
            3: w = {6'b10111, 10'($urandom)};
            4: w = {6'b101011, 10'($urandom)};
            default: w = 16'($urandom);
        endcase
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd90817));
        repeat (3) @(negedge clk);
        #1;
        check(!uop_valid && !in_ready && !in_illegal, "R10 reset state",
              int'({uop_valid, in_ready, in_illegal}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!uop_valid && !in_ready, "R10 idle after reset", int'(uop_valid), 0);

        // Directed corner cases
        run_one({6'b101110, 2'b00, 4'd4, 2'd0, 2'b10}, 1'b0);   // R3 push ra only, 16 bytes
        run_one({6'b101110, 2'b00, 4'd15, 2'd3, 2'b10}, 1'b0);  // R3 R5 full list, 112 bytes
        run_one({6'b101110, 2'b10, 4'd14, 2'd1, 2'b10}, 1'b0);  // R4 pop to x25
        run_one({6'b101111, 2'b10, 4'd7, 2'd2, 2'b10}, 1'b0);   // R6 return
        run_one({6'b101111, 2'b00, 4'd15, 2'd0, 2'b10}, 1'b1);  // R6 return with a0 clear
        run_one({6'b101011, 3'd0, 2'b11, 3'd7, 2'b10}, 1'b0);   // R7 to a0/a1
        run_one({6'b101011, 3'd2, 2'b01, 3'd1, 2'b10}, 1'b0);   // R7 from a0/a1
        run_one({6'b101011, 3'd5, 2'b11, 3'd5, 2'b10}, 1'b0);   // R7 same register illegal
        run_one({6'b101110, 2'b00, 4'd3, 2'd0, 2'b10}, 1'b0);   // R2 reserved list code
        run_one({6'b101110, 2'b00, 4'd8, 2'd0, 2'b01}, 1'b0);   // R1 wrong low bits
        run_one({6'b101110, 2'b01, 4'd8, 2'd0, 2'b10}, 1'b0);   // R1 bad sub-select
        run_one({6'b101011, 3'd1, 2'b10, 3'd2, 2'b10}, 1'b0);   // R1 bad move select

        // R9 flush partway through a long push
        in_instr = {6'b101110, 2'b00, 4'd15, 2'd0, 2'b10};
        in_valid = 1'b1;
        uop_ready = 1'b1;
        repeat (4) @(negedge clk);
        flush = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        flush = 1'b0;
        uop_ready = 1'b0;
        #1;
        check(!uop_valid && !in_ready, "R9 idle after flush", int'({uop_valid, in_ready}), 0);
        @(negedge clk);
        #1;
        check(!uop_valid, "R9 stays idle", int'(uop_valid), 0);
        run_one({6'b101111, 2'b00, 4'd5, 2'd1, 2'b10}, 1'b0);   // R9 recovery

        for (int n = 0; n < 400; n++) begin
            run_one(rand_word(), 1'b0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule